// File: doc/BRIEF.md
# Braking Resistor Thermal Accumulator

This block tracks how hot a braking resistor is. It keeps a saturating energy accumulator that is scaled in percent of the resistor's maximum temperature. On every time-base tick the accumulator rises while the gated braking switch is on. The rise per tick is set so that continuous braking from ambient reaches 100% after a programmed full-power on-time. On every tick while the switch is off, the accumulator falls by 100% divided by a programmed full-power braking period. That decay rate stands for the average power the resistor can shed.

When the accumulator reaches 100%, a 2-bit mode input picks the response:

- **Latched trip:** the block raises a latched trip. The trip holds the braking switch off until a clear input is pulsed.
- **Hysteretic cutout:** the block forces the braking switch off without a trip. Braking is allowed again once the level drops below 95%. This lets several resistors on a shared DC bus hand load to one another.

The controller's braking request passes through as the braking enable whenever neither condition holds.

Top module: `brake_heat_guard`

## Requirements
- R1: After reset the level reads 0, the trip flag is low and no cutout is active, so the braking enable equals the braking request.
- R2: On each tick with the braking enable high, the internal accumulator grows by floor(256000 / on_time). Here 100% = 256000 internal units (8 fraction bits over 0.1% steps), and the level output is floor(accumulator / 256) in 0.1% steps, so 1000 means 100.0%.
- R3: On each tick with the braking enable low, the accumulator shrinks by floor(256000 / period) and stops at 0.
- R4: Without a tick the accumulator and the level do not change.
- R5: The accumulator never exceeds 101.0% (level 1010, internal 258560), saturating there.
- R6: An on-time or period of 0 is treated as 1 tick.
- R7: With mode bit 1 low (modes 0 and 1), the trip flag rises on the same clock edge at which the accumulator reaches at least 100%.
- R8: The trip flag stays high until trip_clr is asserted. A clear while the level is still at or above 100% is followed by a new trip one cycle later.
- R9: With mode bit 1 high (modes 2 and 3), reaching 100% drops the braking enable without raising the trip flag.
- R10: A cutout persists while the level is 950 or more. It ends on the edge at which the level falls below 950.
- R11: The braking enable is high only when the braking request is high, the trip flag is low and no cutout is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base strobe, one cycle per model step |
| brake_req | input | 1 | Braking request from the controller |
| mode | input | 2 | Overload response; bit 1 low = trip, high = cutout |
| on_time | input | 16 | Full-power on-time in ticks |
| period | input | 16 | Full-power braking period in ticks |
| trip_clr | input | 1 | Clears a latched trip |
| brake_en | output | 1 | Gated braking switch enable |
| trip | output | 1 | Latched overload trip |
| level | output | 10 | Accumulator level in 0.1% steps |

## Verification
The level, the trip flag and the cutout state all register on the clock edge that samples a tick. Each of them is therefore due one cycle after the tick is driven. The braking enable follows combinationally from those registers and from the braking request in the same cycle. The bench drives every input just after a falling edge and samples every output at the next falling edge. It counts ticks per step, so each expected value is taken exactly after the edge that produced it. A trip clear takes effect one edge later, and any re-trip one edge after that; the bench samples both cycles separately.

// File: rtl/brake_heat_pkg.sv
package brake_heat_pkg;

  // level units: 0.1 percent
  localparam int unsigned PCT_FULL = 1000;
  localparam int unsigned PCT_LOW  = 950;
  localparam int unsigned PCT_CEIL = 1010;

  typedef enum logic [1:0] {
    RESP_TRIP_A = 2'd0,
    RESP_TRIP_B = 2'd1,
    RESP_CUT_A  = 2'd2,
    RESP_CUT_B  = 2'd3
  } resp_e;

  // 100% divided by a time count in ticks; zero counts as one tick
  function automatic logic [31:0] step_of(input logic [31:0] full_raw,
                                          input logic [31:0] ticks);
    logic [31:0] t;
    t = (ticks == 32'd0) ? 32'd1 : ticks;
    return full_raw / t;
  endfunction

  // saturating add or subtract of one step
  function automatic logic [31:0] sat_step(input logic [31:0] acc,
                                           input logic [31:0] step,
                                           input logic        up,
                                           input logic [31:0] ceil_raw);
    logic [32:0] sum;
    if (up) begin
      sum = {1'b0, acc} + {1'b0, step};
      return (sum > {1'b0, ceil_raw}) ? ceil_raw : sum[31:0];
    end
    return (step >= acc) ? 32'd0 : acc - step;
  endfunction

  function automatic bit is_cut_mode(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/brake_step_gen.sv
module brake_step_gen
  import brake_heat_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int ACC_W  = 19,
  parameter int FRAC_W = 8
) (
  input  logic [TIME_W-1:0] on_time,
  input  logic [TIME_W-1:0] period,
  output logic [ACC_W-1:0]  rise_step,
  output logic [ACC_W-1:0]  fall_step
);
  localparam logic [31:0] FULL_RAW = 32'(PCT_FULL) << FRAC_W;

  logic [31:0] rise_w, fall_w;

  always_comb begin
    rise_w = step_of(FULL_RAW, 32'(on_time));
    fall_w = step_of(FULL_RAW, 32'(period));
  end

  assign rise_step = rise_w[ACC_W-1:0];
  assign fall_step = fall_w[ACC_W-1:0];

  // R6: a zero time never gives a zero step
  always_comb begin
    a_r6_step_nonzero: assert (rise_step != '0 && fall_step != '0);
  end
endmodule

// File: rtl/brake_accum.sv
module brake_accum
  import brake_heat_pkg::*;
#(
  parameter int ACC_W  = 19,
  parameter int FRAC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             heating,
  input  logic [ACC_W-1:0] rise_step,
  input  logic [ACC_W-1:0] fall_step,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] acc_nxt
);
  localparam logic [31:0] CEIL_RAW = 32'(PCT_CEIL) << FRAC_W;

  logic [31:0] stepped;
  logic [ACC_W-1:0] step_sel;

  always_comb begin
    step_sel = heating ? rise_step : fall_step;
    stepped  = sat_step(32'(acc_q), 32'(step_sel), heating, CEIL_RAW);
    acc_nxt  = tick ? stepped[ACC_W-1:0] : acc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end

  // R4: no tick, no movement
  a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc_q));
  // R5: ceiling
  a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    32'(acc_q) <= CEIL_RAW);
  // R3: floor at zero
  a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !heating && acc_q == '0 |=> acc_q == '0);
endmodule

// File: rtl/brake_guard.sv
module brake_guard
  import brake_heat_pkg::*;
#(
  parameter int ACC_W  = 19,
  parameter int FRAC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             trip_clr,
  input  logic             tick,
  input  logic [ACC_W-1:0] acc_nxt,
  output logic             trip_q,
  output logic             cut_q
);
  localparam logic [31:0] FULL_RAW = 32'(PCT_FULL) << FRAC_W;
  localparam logic [31:0] LOW_RAW  = 32'(PCT_LOW) << FRAC_W;

  logic at_full, above_low, cut_mode;
  logic trip_d, cut_d;

  always_comb begin
    cut_mode  = is_cut_mode(mode);
    at_full   = 32'(acc_nxt) >= FULL_RAW;
    above_low = 32'(acc_nxt) >= LOW_RAW;
    trip_d    = !trip_clr && (trip_q || (!cut_mode && at_full));
    cut_d     = cut_mode && (at_full || (cut_q && above_low));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
      cut_q  <= 1'b0;
    end else begin
      trip_q <= trip_d;
      cut_q  <= cut_d;
    end
  end

  // R8: trip latched until cleared
  a_r8_trip_latched: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q && !trip_clr |=> trip_q);
  // R9: cutout mode never starts a trip
  a_r9_no_new_trip: assert property (@(posedge clk) disable iff (!rst_n)
    cut_mode && !trip_q |=> !trip_q);
  // R10: cutout holds while no tick can lower the level
  a_r10_cut_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cut_q && cut_mode && !tick |=> cut_q);
endmodule

// File: rtl/brake_heat_guard.sv
module brake_heat_guard
  import brake_heat_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int FRAC_W = 8,
  parameter int LVL_W  = $clog2(PCT_CEIL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              brake_req,
  input  logic [1:0]        mode,
  input  logic [TIME_W-1:0] on_time,
  input  logic [TIME_W-1:0] period,
  input  logic              trip_clr,
  output logic              brake_en,
  output logic              trip,
  output logic [LVL_W-1:0]  level
);
  localparam int unsigned CEIL_RAW = PCT_CEIL << FRAC_W;
  localparam int          ACC_W    = $clog2(2 * CEIL_RAW + 1);

  logic [ACC_W-1:0] rise_step, fall_step, acc_q, acc_nxt;
  logic             trip_q, cut_q;
  logic [ACC_W-1:0] lvl_wide;

  brake_step_gen #(.TIME_W(TIME_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_step (
    .on_time  (on_time),
    .period   (period),
    .rise_step(rise_step),
    .fall_step(fall_step)
  );

  brake_accum #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .heating  (brake_en),
    .rise_step(rise_step),
    .fall_step(fall_step),
    .acc_q    (acc_q),
    .acc_nxt  (acc_nxt)
  );

  brake_guard #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .trip_clr(trip_clr),
    .tick    (tick),
    .acc_nxt (acc_nxt),
    .trip_q  (trip_q),
    .cut_q   (cut_q)
  );

  always_comb begin
    lvl_wide = acc_q >> FRAC_W;
    level    = lvl_wide[LVL_W-1:0];
    brake_en = brake_req && !trip_q && !cut_q;
    trip     = trip_q;
  end

  // R7: level at full in trip mode leads to trip
  a_r7_trip_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] && 32'(level) >= PCT_FULL && !trip_clr |=> trip);
  // R11: enable never high during a trip
  a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> !brake_en);
endmodule

// File: tb/brake_heat_guard_tb.sv
module brake_heat_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       brake_req = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [15:0] on_time = 16'd10;
  logic [15:0] period = 16'd100;
  logic       trip_clr = 1'b0;
  logic       brake_en, trip;
  logic [9:0] level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  brake_heat_guard u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .brake_req(brake_req),
    .mode(mode), .on_time(on_time), .period(period), .trip_clr(trip_clr),
    .brake_en(brake_en), .trip(trip), .level(level)
  );

  typedef struct packed {
    logic [1:0]  m;
    logic [15:0] on;
    logic [15:0] per;
    logic        req;
    logic [7:0]  n;
    logic [9:0]  lvl;
    logic        trp;
    logic        en;
  } vec_t;

  // rows: R2 half, R7 trip, R9 cutout, R2 floor rounding, R5 ceiling, R6 zero on-time, R3 idle floor
  localparam vec_t TABLE [7] = '{
    '{2'd0, 16'd10, 16'd100, 1'b1, 8'd5,  10'd500,  1'b0, 1'b1},
    '{2'd0, 16'd10, 16'd100, 1'b1, 8'd10, 10'd1000, 1'b1, 1'b0},
    '{2'd2, 16'd10, 16'd100, 1'b1, 8'd10, 10'd1000, 1'b0, 1'b0},
    '{2'd1, 16'd3,  16'd100, 1'b1, 8'd3,  10'd999,  1'b0, 1'b1},
    '{2'd0, 16'd3,  16'd100, 1'b1, 8'd4,  10'd1010, 1'b1, 1'b0},
    '{2'd1, 16'd0,  16'd100, 1'b1, 8'd1,  10'd1000, 1'b1, 1'b0},
    '{2'd3, 16'd5,  16'd0,   1'b0, 8'd3,  10'd0,    1'b0, 1'b0}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; trip_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  initial begin
    // R1 reset state
    brake_req = 1'b1;
    do_reset();
    @(negedge clk);
    chk("R1 level", int'(level), 0);
    chk("R1 trip", int'(trip), 0);
    chk("R1 enable", int'(brake_en), 1);

    // table walk
    foreach (TABLE[k]) begin
      mode = TABLE[k].m; on_time = TABLE[k].on; period = TABLE[k].per;
      brake_req = TABLE[k].req;
      do_reset();
      ticks(int'(TABLE[k].n));
      chk($sformatf("table row %0d level (R2/R3/R5/R6)", k), int'(level), int'(TABLE[k].lvl));
      chk($sformatf("table row %0d trip (R7/R9)", k), int'(trip), int'(TABLE[k].trp));
      chk($sformatf("table row %0d enable (R11)", k), int'(brake_en), int'(TABLE[k].en));
    end

    // R4 no change without tick, then R3 decay
    mode = 2'd0; on_time = 16'd10; period = 16'd20; brake_req = 1'b1;
    do_reset();
    ticks(5);
    repeat (20) @(negedge clk);
    chk("R4 level held", int'(level), 500);
    brake_req = 1'b0;
    ticks(2);
    chk("R3 decay", int'(level), 400);
    // R6 zero period empties in one tick
    period = 16'd0;
    ticks(1);
    chk("R6 zero period", int'(level), 0);

    // R10 cutout hysteresis
    mode = 2'd3; on_time = 16'd10; period = 16'd20; brake_req = 1'b1;
    do_reset();
    ticks(10);
    chk("R9 cut level", int'(level), 1000);
    chk("R9 cut enable", int'(brake_en), 0);
    ticks(1);
    chk("R10 at 95 level", int'(level), 950);
    chk("R10 at 95 still cut", int'(brake_en), 0);
    ticks(1);
    chk("R10 below 95 level", int'(level), 900);
    chk("R10 below 95 enable", int'(brake_en), 1);
    chk("R9 no trip", int'(trip), 0);
    ticks(1);
    chk("R10 re-cut enable", int'(brake_en), 0);

    // R8 latched trip and clear
    mode = 2'd1; brake_req = 1'b1;
    do_reset();
    ticks(10);
    chk("R7 trip", int'(trip), 1);
    ticks(10);
    chk("R8 level decayed", int'(level), 500);
    chk("R8 trip held", int'(trip), 1);
    chk("R11 enable off in trip", int'(brake_en), 0);
    @(negedge clk) trip_clr = 1'b1;
    @(negedge clk) trip_clr = 1'b0;
    chk("R8 cleared", int'(trip), 0);
    chk("R11 enable after clear", int'(brake_en), 1);

    // R8 re-trip when cleared at full
    mode = 2'd0;
    do_reset();
    ticks(10);
    @(negedge clk) trip_clr = 1'b1;
    @(negedge clk) trip_clr = 1'b0;
    chk("R8 clear at full", int'(trip), 0);
    @(negedge clk);
    chk("R8 re-trip", int'(trip), 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule